// File: doc/BRIEF.md
# Debug Hit Qualifier for Breakpoints and Watchpoints

This block decides whether an address match reported by one of the hardware breakpoint or watchpoint comparators turns into a debug exception. The address compare happens elsewhere. Each comparator presents only a hit bit here, together with its control word. Each hit is qualified against the comparator's own enable bit, its security-state selector and its privilege-level selectors. It can also be qualified against a linked context comparator, which is one of the top breakpoint slots and holds a 32-bit context value.

A global monitor enable gates every match. Among the matches, watchpoints take precedence over breakpoints, and within each kind the lowest index wins. The winner is reported one clock after the inputs that caused it. The report gives the abort kind (instruction-fetch for a breakpoint, data for a watchpoint), the winning index, whether the exception targets the current level, and a fault status code. For a watchpoint the report also carries the write flag and the faulting address.

Control word fields, by bit position: [0] enable, [2:1] privilege selector (bit 1 allows level 1, bit 2 allows level 0), [13] higher-level enable, [15:14] security selector, [19:16] linked slot number, [20] link enable, [23:20] context-slot type.

Top module: `dbg_hit_matcher`

## Requirements
- R1: While `mon_en` is 0, no hit is reported (`exc_valid` stays 0) whatever the comparators present.
- R2: A comparator whose control bit 0 is 0 never matches.
- R3: Security selector bits [15:14] set to 0 match in either state. Set to 2, they match only when `secure_st` is 1. Set to 1 or 3, they match only when `secure_st` is 0.
- R4: At level 2 or 3 a match needs control bit 13. At level 1 it needs control bit 1. At level 0 it needs control bit 2.
- R5: With control bit 20 set, a match also needs all of the following: the slot number in bits [19:16] lies in NUM_BP-NUM_CTX .. NUM_BP-1; that breakpoint slot is enabled (bit 0) and has type bits [23:20] equal to 3; `cur_el` is 0 or 1; and its value word equals `context_id`. Any other type value (5, 9, 11 or another) never links.
- R6: Among matching comparators of one kind, the lowest index is reported.
- R7: Any watchpoint match takes precedence over all breakpoint matches. `exc_is_data` is 1 for a watchpoint and 0 for a breakpoint.
- R8: `exc_fsr` is 10'h222 when `ext_addr` is 1 and 10'h002 when it is 0.
- R9: `exc_same_el` is 1 exactly when `target_el` equals `cur_el`.
- R10: A watchpoint report carries `wp_is_write` on `exc_wnr` and `wp_hit_addr` on `exc_addr`. A breakpoint report drives both to 0.
- R11: Outputs are registered with one cycle of latency. After reset, and on any cycle without a hit, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_en | input | 1 | Global debug monitor enable |
| cur_el | input | 2 | Current exception level |
| target_el | input | 2 | Level that takes debug exceptions |
| secure_st | input | 1 | 1 when executing in secure state |
| ext_addr | input | 1 | Selects the long fault status format |
| context_id | input | CTXID_W | Current context identifier |
| bp_ctrl | input | NUM_BP*32 | Breakpoint control words, slot i at [32i +: 32] |
| bp_value | input | NUM_BP*CTXID_W | Breakpoint value words, used by context slots |
| bp_addr_hit | input | NUM_BP | Per-breakpoint address match |
| wp_ctrl | input | NUM_WP*32 | Watchpoint control words |
| wp_addr_hit | input | NUM_WP | Per-watchpoint address match |
| wp_is_write | input | 1 | Access causing the watchpoint hit is a write |
| wp_hit_addr | input | ADDR_W | Address of the watchpoint access |
| exc_valid | output | 1 | A debug exception is raised |
| exc_is_data | output | 1 | 1 data abort (watchpoint), 0 fetch abort (breakpoint) |
| exc_index | output | IDX_W | Winning comparator index |
| exc_same_el | output | 1 | Exception taken at the current level |
| exc_fsr | output | 10 | Fault status code |
| exc_wnr | output | 1 | Write-not-read of the watchpoint access |
| exc_addr | output | ADDR_W | Faulting address for a watchpoint |

## Verification
A table of single-comparator cases walks breakpoint 0 through every privilege-level and security selector combination, so that a wrongly mapped selector bit or a swapped state shows up as a single mismatched row. Directed patterns then present several simultaneous hits, to separate lowest-index order from highest-index order and to check that watchpoints take precedence over breakpoints. Linked-context cases change one condition at a time: the value, the slot range, the slot type, the slot enable and the level. Each case can therefore only pass if that condition is really checked. Further cases vary `ext_addr`, `target_el` and the watchpoint attributes to show that the report fields follow their own inputs.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;

   localparam int CTRL_W     = 32;
   localparam int FSR_W      = 10;
   localparam int TYPE_LO    = 20;
   localparam logic [3:0]       CTX_TYPE  = 4'd3;
   localparam logic [FSR_W-1:0] FSR_LONG  = 10'h222;
   localparam logic [FSR_W-1:0] FSR_SHORT = 10'h002;

   typedef struct packed {
      logic       link;
      logic [3:0] lbn;
      logic [1:0] ssc;
      logic       hmc;
      logic [1:0] pac;
      logic       en;
   } ctrl_t;

   function automatic ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] r);
      ctrl_t c;
      c.en   = r[0];
      c.pac  = r[2:1];
      c.hmc  = r[13];
      c.ssc  = r[15:14];
      c.lbn  = r[19:16];
      c.link = r[20];
      return c;
   endfunction

endpackage

// File: rtl/dbgm_ctx_link.sv
module dbgm_ctx_link
   import dbgm_pkg::*;
#(
   parameter int NUM_BP  = 6,
   parameter int NUM_CTX = 2,
   parameter int CTXID_W = 32
) (
   input  logic [NUM_BP*CTRL_W-1:0]  bp_ctrl,
   input  logic [NUM_BP*CTXID_W-1:0] bp_value,
   input  logic [1:0]                cur_el,
   input  logic [CTXID_W-1:0]        context_id,
   output logic [NUM_BP-1:0]         ctx_ok
);
   localparam int CTX_LO = NUM_BP - NUM_CTX;

   for (genvar i = 0; i < NUM_BP; i++) begin : g_slot
      if (i >= CTX_LO) begin : g_ctx
         logic en_s;
         logic type_s;
         assign en_s   = bp_ctrl[i*CTRL_W];
         assign type_s = (bp_ctrl[i*CTRL_W+TYPE_LO +: 4] == CTX_TYPE);
         assign ctx_ok[i] = en_s && type_s && (cur_el <= 2'd1) &&
                            (bp_value[i*CTXID_W +: CTXID_W] == context_id);
      end else begin : g_plain
         assign ctx_ok[i] = 1'b0;
      end
   end

endmodule

// File: rtl/dbgm_qual.sv
module dbgm_qual
   import dbgm_pkg::*;
#(
   parameter int NUM_BP = 6
) (
   input  logic [CTRL_W-1:0] ctrl,
   input  logic              addr_hit,
   input  logic              secure_st,
   input  logic [1:0]        cur_el,
   input  logic [NUM_BP-1:0] ctx_ok,
   output logic              match
);
   ctrl_t       c;
   logic [15:0] ctx_pad;
   logic        sec_ok;
   logic        el_ok;
   logic        link_ok;

   assign c       = unpack_ctrl(ctrl);
   assign ctx_pad = 16'(ctx_ok);

   always_comb begin
      unique case (c.ssc)
         2'd0:    sec_ok = 1'b1;
         2'd2:    sec_ok = secure_st;
         default: sec_ok = !secure_st;
      endcase
   end

   always_comb begin
      unique case (cur_el)
         2'd0:    el_ok = c.pac[1];
         2'd1:    el_ok = c.pac[0];
         default: el_ok = c.hmc;
      endcase
   end

   assign link_ok = !c.link || ctx_pad[c.lbn];
   assign match   = addr_hit && c.en && sec_ok && el_ok && link_ok;

endmodule

// File: rtl/dbgm_first.sv
module dbgm_first #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  grant
);
   always_comb begin
      any   = 1'b0;
      idx   = '0;
      grant = '0;
      for (int i = N-1; i >= 0; i--) begin
         if (req[i]) begin
            any      = 1'b1;
            idx      = IW'(i);
            grant    = '0;
            grant[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dbg_hit_matcher.sv
module dbg_hit_matcher
   import dbgm_pkg::*;
#(
   parameter int NUM_BP  = 6,
   parameter int NUM_WP  = 4,
   parameter int NUM_CTX = 2,
   parameter int ADDR_W  = 32,
   parameter int CTXID_W = 32,
   localparam int NUM_MAX = (NUM_BP > NUM_WP) ? NUM_BP : NUM_WP,
   localparam int IDX_W   = (NUM_MAX > 1) ? $clog2(NUM_MAX) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      mon_en,
   input  logic [1:0]                cur_el,
   input  logic [1:0]                target_el,
   input  logic                      secure_st,
   input  logic                      ext_addr,
   input  logic [CTXID_W-1:0]        context_id,
   input  logic [NUM_BP*32-1:0]      bp_ctrl,
   input  logic [NUM_BP*CTXID_W-1:0] bp_value,
   input  logic [NUM_BP-1:0]         bp_addr_hit,
   input  logic [NUM_WP*32-1:0]      wp_ctrl,
   input  logic [NUM_WP-1:0]         wp_addr_hit,
   input  logic                      wp_is_write,
   input  logic [ADDR_W-1:0]         wp_hit_addr,
   output logic                      exc_valid,
   output logic                      exc_is_data,
   output logic [IDX_W-1:0]          exc_index,
   output logic                      exc_same_el,
   output logic [9:0]                exc_fsr,
   output logic                      exc_wnr,
   output logic [ADDR_W-1:0]         exc_addr
);

   if (NUM_BP < 1 || NUM_BP > 16) begin : g_bad_bp
      $error("NUM_BP must be 1..16");
   end
   if (NUM_WP < 1 || NUM_WP > 16) begin : g_bad_wp
      $error("NUM_WP must be 1..16");
   end
   if (NUM_CTX < 0 || NUM_CTX > NUM_BP) begin : g_bad_ctx
      $error("NUM_CTX must be 0..NUM_BP");
   end
   if (ADDR_W < 1 || CTXID_W < 1) begin : g_bad_w
      $error("widths must be positive");
   end

   logic [NUM_BP-1:0] ctx_ok;
   logic [NUM_BP-1:0] bp_match;
   logic [NUM_WP-1:0] wp_match;
   logic [NUM_BP-1:0] bp_grant;
   logic [NUM_WP-1:0] wp_grant;
   logic              bp_any;
   logic              wp_any;
   logic [IDX_W-1:0]  bp_idx;
   logic [IDX_W-1:0]  wp_idx;

   dbgm_ctx_link #(
      .NUM_BP (NUM_BP),
      .NUM_CTX(NUM_CTX),
      .CTXID_W(CTXID_W)
   ) u_ctx (
      .bp_ctrl   (bp_ctrl),
      .bp_value  (bp_value),
      .cur_el    (cur_el),
      .context_id(context_id),
      .ctx_ok    (ctx_ok)
   );

   for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
      dbgm_qual #(.NUM_BP(NUM_BP)) u_q (
         .ctrl     (bp_ctrl[i*32 +: 32]),
         .addr_hit (bp_addr_hit[i] && mon_en),
         .secure_st(secure_st),
         .cur_el   (cur_el),
         .ctx_ok   (ctx_ok),
         .match    (bp_match[i])
      );
   end

   for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
      dbgm_qual #(.NUM_BP(NUM_BP)) u_q (
         .ctrl     (wp_ctrl[i*32 +: 32]),
         .addr_hit (wp_addr_hit[i] && mon_en),
         .secure_st(secure_st),
         .cur_el   (cur_el),
         .ctx_ok   (ctx_ok),
         .match    (wp_match[i])
      );
   end

   dbgm_first #(.N(NUM_BP), .IW(IDX_W)) u_bp_first (
      .req(bp_match), .any(bp_any), .idx(bp_idx), .grant(bp_grant)
   );

   dbgm_first #(.N(NUM_WP), .IW(IDX_W)) u_wp_first (
      .req(wp_match), .any(wp_any), .idx(wp_idx), .grant(wp_grant)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || !(wp_any || bp_any)) begin
         exc_valid   <= 1'b0;
         exc_is_data <= 1'b0;
         exc_index   <= '0;
         exc_same_el <= 1'b0;
         exc_fsr     <= '0;
         exc_wnr     <= 1'b0;
         exc_addr    <= '0;
      end else begin
         exc_valid   <= 1'b1;
         exc_is_data <= wp_any;
         exc_index   <= wp_any ? wp_idx : bp_idx;
         exc_same_el <= (target_el == cur_el);
         exc_fsr     <= ext_addr ? FSR_LONG : FSR_SHORT;
         exc_wnr     <= wp_any && wp_is_write;
         exc_addr    <= wp_any ? wp_hit_addr : '0;
      end
   end

   // R1
   no_hit_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> $past(mon_en));

   // R6
   bp_grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bp_grant) && ((bp_grant & ~bp_match) == '0));

   // R6
   wp_grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wp_grant) && ((wp_grant & ~wp_match) == '0));

   // R8
   fsr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (exc_fsr == FSR_LONG || exc_fsr == FSR_SHORT));

   // R10
   bp_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && !exc_is_data) |-> (exc_addr == '0 && !exc_wnr));

   // R11
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_valid |-> (exc_fsr == '0 && exc_index == '0 && !exc_is_data));

endmodule

// File: tb/test_dbg_hit_matcher.sv
`timescale 1ns/1ps
module test_dbg_hit_matcher;
   localparam int NBP = 6;
   localparam int NWP = 4;
   localparam int AW  = 32;
   localparam int CW  = 32;
   localparam int IW  = 3;
   localparam real HALF = 10.0;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            mon_en;
   logic [1:0]      cur_el, target_el;
   logic            secure_st, ext_addr;
   logic [CW-1:0]   context_id;
   logic [NBP*32-1:0] bp_ctrl;
   logic [NBP*CW-1:0] bp_value;
   logic [NBP-1:0]  bp_addr_hit;
   logic [NWP*32-1:0] wp_ctrl;
   logic [NWP-1:0]  wp_addr_hit;
   logic            wp_is_write;
   logic [AW-1:0]   wp_hit_addr;
   logic            exc_valid, exc_is_data, exc_same_el, exc_wnr;
   logic [IW-1:0]   exc_index;
   logic [9:0]      exc_fsr;
   logic [AW-1:0]   exc_addr;

   int n_checks = 0;
   int n_fail   = 0;

   always #(HALF) clk = ~clk;

   dbg_hit_matcher i_dbg_hit_matcher (
      .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .cur_el(cur_el),
      .target_el(target_el), .secure_st(secure_st), .ext_addr(ext_addr),
      .context_id(context_id), .bp_ctrl(bp_ctrl), .bp_value(bp_value),
      .bp_addr_hit(bp_addr_hit), .wp_ctrl(wp_ctrl), .wp_addr_hit(wp_addr_hit),
      .wp_is_write(wp_is_write), .wp_hit_addr(wp_hit_addr),
      .exc_valid(exc_valid), .exc_is_data(exc_is_data), .exc_index(exc_index),
      .exc_same_el(exc_same_el), .exc_fsr(exc_fsr), .exc_wnr(exc_wnr),
      .exc_addr(exc_addr)
   );

   function automatic logic [31:0] mk(input logic en, input logic [1:0] pac,
      input logic hmc, input logic [1:0] ssc, input logic [3:0] lbn, input logic link);
      logic [31:0] r = '0;
      r[0] = en; r[2:1] = pac; r[13] = hmc; r[15:14] = ssc;
      r[19:16] = lbn; r[20] = link;
      return r;
   endfunction

   localparam logic [31:0] GOOD    = 32'h0000_2007;  // en, both levels, higher level
   localparam logic [31:0] CTXSLOT = 32'h0030_0001;  // enabled, type 3
   localparam logic [31:0] CTXVAL  = 32'hCAFE_0001;

   typedef struct packed {
      logic [31:0] ctrl;
      logic [1:0]  el;
      logic        sec;
      logic        exp;
   } vec_t;

   localparam vec_t VECS [13] = '{
      '{mk(1,2'd3,1,2'd0,4'd0,0), 2'd0, 1'b0, 1'b1},  // R4 baseline
      '{mk(0,2'd3,1,2'd0,4'd0,0), 2'd0, 1'b0, 1'b0},  // R2 disabled
      '{mk(1,2'd1,1,2'd0,4'd0,0), 2'd0, 1'b0, 1'b0},  // R4 level0 needs bit2
      '{mk(1,2'd2,0,2'd0,4'd0,0), 2'd0, 1'b0, 1'b1},  // R4
      '{mk(1,2'd2,1,2'd0,4'd0,0), 2'd1, 1'b0, 1'b0},  // R4 level1 needs bit1
      '{mk(1,2'd1,0,2'd0,4'd0,0), 2'd1, 1'b0, 1'b1},  // R4
      '{mk(1,2'd3,0,2'd0,4'd0,0), 2'd2, 1'b0, 1'b0},  // R4 level2 needs bit13
      '{mk(1,2'd0,1,2'd0,4'd0,0), 2'd3, 1'b0, 1'b1},  // R4
      '{mk(1,2'd3,1,2'd2,4'd0,0), 2'd0, 1'b0, 1'b0},  // R3 secure only
      '{mk(1,2'd3,1,2'd2,4'd0,0), 2'd0, 1'b1, 1'b1},  // R3
      '{mk(1,2'd3,1,2'd1,4'd0,0), 2'd0, 1'b1, 1'b0},  // R3 non-secure only
      '{mk(1,2'd3,1,2'd3,4'd0,0), 2'd0, 1'b0, 1'b1},  // R3
      '{mk(1,2'd3,1,2'd0,4'd0,0), 2'd1, 1'b1, 1'b1}   // R3 either state
   };

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic expect_out(input string req, input logic v, input logic data,
      input logic [IW-1:0] idx, input logic same, input logic [9:0] fsr,
      input logic wnr, input logic [AW-1:0] addr);
      chk(req, "valid", 64'(exc_valid), 64'(v));
      if (v) begin
         chk(req, "is_data", 64'(exc_is_data), 64'(data));
         chk(req, "index",   64'(exc_index),   64'(idx));
         chk(req, "same_el", 64'(exc_same_el), 64'(same));
         chk(req, "fsr",     64'(exc_fsr),     64'(fsr));
         chk(req, "wnr",     64'(exc_wnr),     64'(wnr));
         chk(req, "addr",    64'(exc_addr),    64'(addr));
      end else begin
         chk(req, "idle fsr", 64'(exc_fsr), 64'd0);
      end
   endtask

   task automatic idle();
      mon_en = 1'b1; cur_el = 2'd0; target_el = 2'd0; secure_st = 1'b0;
      ext_addr = 1'b0; context_id = CTXVAL; bp_ctrl = '0; bp_value = '0;
      bp_addr_hit = '0; wp_ctrl = '0; wp_addr_hit = '0; wp_is_write = 1'b0;
      wp_hit_addr = '0;
      bp_ctrl[4*32 +: 32]  = CTXSLOT;
      bp_value[4*CW +: CW] = CTXVAL;
   endtask

   // drive at negedge, output registered at next posedge, sample at following negedge
   task automatic step();
      @(negedge clk);
   endtask

   task automatic link_case(input string req, input logic exp);
      bp_addr_hit[0] = 1'b1;
      step();
      expect_out(req, exp, 1'b0, 3'd0, 1'b1, 10'h002, 1'b0, '0);
      idle();
   endtask

   initial begin
      #(2.0*HALF*150000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      idle();
      rst_n = 1'b0;
      bp_ctrl[0 +: 32] = GOOD; bp_addr_hit[0] = 1'b1;
      repeat (3) @(negedge clk);
      // R11 reset holds outputs at zero even with a hit present
      expect_out("R11", 1'b0, 0, 0, 0, 0, 0, '0);
      chk("R11", "reset index", 64'(exc_index), 64'd0);
      rst_n = 1'b1;
      idle();
      step();
      expect_out("R11", 1'b0, 0, 0, 0, 0, 0, '0);

      // table walk over breakpoint 0
      foreach (VECS[k]) begin
         idle();
         bp_ctrl[0 +: 32] = VECS[k].ctrl;
         cur_el = VECS[k].el; target_el = VECS[k].el;
         secure_st = VECS[k].sec;
         bp_addr_hit[0] = 1'b1;
         step();
         expect_out(VECS[k].exp ? "R4/R3 match" : "R2/R3/R4 block",
                    VECS[k].exp, 1'b0, 3'd0, 1'b1, 10'h002, 1'b0, '0);
      end

      // R11 one cycle latency
      idle(); step();
      bp_ctrl[0 +: 32] = GOOD; bp_addr_hit[0] = 1'b1;
      #2;
      chk("R11", "no early output", 64'(exc_valid), 64'd0);
      step();
      chk("R11", "output after one edge", 64'(exc_valid), 64'd1);
      idle(); step();
      expect_out("R11", 1'b0, 0, 0, 0, 0, 0, '0);

      // R1 global enable
      bp_ctrl[0 +: 32] = GOOD; bp_addr_hit[0] = 1'b1;
      wp_ctrl[0 +: 32] = GOOD; wp_addr_hit[0] = 1'b1;
      mon_en = 1'b0;
      step();
      expect_out("R1", 1'b0, 0, 0, 0, 0, 0, '0);

      // R6 lowest index
      idle();
      bp_ctrl[1*32 +: 32] = GOOD; bp_ctrl[3*32 +: 32] = GOOD;
      bp_addr_hit = 6'b001010;
      step();
      expect_out("R6", 1'b1, 1'b0, 3'd1, 1'b1, 10'h002, 1'b0, '0);
      bp_ctrl[1*32 +: 32] = 32'h0;
      step();
      expect_out("R6 disabled lower", 1'b1, 1'b0, 3'd3, 1'b1, 10'h002, 1'b0, '0);
      idle();
      wp_ctrl[1*32 +: 32] = GOOD; wp_ctrl[2*32 +: 32] = GOOD;
      wp_addr_hit = 4'b0110; wp_hit_addr = 32'h0000_8000;
      step();
      expect_out("R6 watch", 1'b1, 1'b1, 3'd1, 1'b1, 10'h002, 1'b0, 32'h0000_8000);

      // R7 and R10 watchpoint over breakpoint
      idle();
      bp_ctrl[0 +: 32] = GOOD; bp_addr_hit[0] = 1'b1;
      wp_ctrl[2*32 +: 32] = GOOD; wp_addr_hit[2] = 1'b1;
      wp_is_write = 1'b1; wp_hit_addr = 32'h1234_5678;
      step();
      expect_out("R7 R10", 1'b1, 1'b1, 3'd2, 1'b1, 10'h002, 1'b1, 32'h1234_5678);
      wp_addr_hit = '0;
      step();
      expect_out("R10 bp clears attrs", 1'b1, 1'b0, 3'd0, 1'b1, 10'h002, 1'b0, '0);

      // R8 fault status format
      ext_addr = 1'b1;
      step();
      expect_out("R8", 1'b1, 1'b0, 3'd0, 1'b1, 10'h222, 1'b0, '0);

      // R9 same level
      ext_addr = 1'b0; cur_el = 2'd1; target_el = 2'd2;
      step();
      expect_out("R9", 1'b1, 1'b0, 3'd0, 1'b0, 10'h002, 1'b0, '0);
      target_el = 2'd1;
      step();
      expect_out("R9", 1'b1, 1'b0, 3'd0, 1'b1, 10'h002, 1'b0, '0);

      // R5 linked context comparator
      idle(); bp_ctrl[0 +: 32] = mk(1,2'd3,1,2'd0,4'd4,1);
      link_case("R5 linked match", 1'b1);
      bp_ctrl[0 +: 32] = mk(1,2'd3,1,2'd0,4'd4,1); context_id = 32'hCAFE_0002;
      link_case("R5 value mismatch", 1'b0);
      bp_ctrl[0 +: 32] = mk(1,2'd3,1,2'd0,4'd2,1);
      bp_ctrl[2*32 +: 32] = CTXSLOT; bp_value[2*CW +: CW] = CTXVAL;
      link_case("R5 slot below range", 1'b0);
      bp_ctrl[0 +: 32] = mk(1,2'd3,1,2'd0,4'd4,1);
      bp_ctrl[4*32 +: 32] = 32'h0050_0001;
      link_case("R5 type 5", 1'b0);
      bp_ctrl[0 +: 32] = mk(1,2'd3,1,2'd0,4'd4,1);
      bp_ctrl[4*32 +: 32] = 32'h00B0_0001;
      link_case("R5 type 11", 1'b0);
      bp_ctrl[0 +: 32] = mk(1,2'd3,1,2'd0,4'd4,1);
      bp_ctrl[4*32 +: 32] = 32'h0030_0000;
      link_case("R5 slot disabled", 1'b0);
      bp_ctrl[0 +: 32] = mk(1,2'd3,1,2'd0,4'd9,1);
      link_case("R5 slot above range", 1'b0);
      bp_ctrl[0 +: 32] = mk(1,2'd3,1,2'd0,4'd5,1);
      bp_ctrl[5*32 +: 32] = CTXSLOT; bp_value[5*CW +: CW] = CTXVAL;
      link_case("R5 top slot", 1'b1);
      bp_ctrl[0 +: 32] = mk(1,2'd3,1,2'd0,4'd4,1);
      cur_el = 2'd2; target_el = 2'd2;
      link_case("R5 level 2 blocks link", 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule